// File: doc/BRIEF.md
# Background Fetch Microprogram Sequencer

This block sets the order of memory fetches for a tile and bitmap background engine. The fetch timing is not fixed in logic. A host loads a small store of 9-bit micro-instructions through an address register and an auto-incrementing data port. The store has 16 words in two banks of eight slots. Bank A uses addresses 0 to 7 and bank B uses addresses 8 to 15.

After the host sets the run bit, the sequencer chooses the bank given by `bankSel`. It keeps that bank until the run bit is cleared. On every fetch cycle (`fetchStep` high) it reads the current slot and decodes it into a fetch request: background plane, access kind, word offset and rotation flag. It then moves to the next slot and wraps inside the bank. The pixel decode, the affine arithmetic and the memory arbiter are downstream and are not part of this block.

Top module: `bg_fetch_seq`

## Requirements
- R1: After reset, `reqValid` is 0, `progAddr` is 0, `reqSlot` is 0 and every store word holds the value 0x100 (a no-access word).
- R2: While `hostDataWe` is high, the word on `hostDataIn` is stored at `progAddr`. On the next edge `progAddr` increments and wraps from 15 to 0. While `hostAddrWe` is high, `progAddr` loads `hostAddrIn`. If both are high, the data is stored at the old address and the address load wins.
- R3: A word is decoded with word offset = bits 2:0, access kind = bits 4:3, rotation = bit 5 and plane = bits 7:6. When bit 5 is 1, the emitted `reqOffset` is 0.
- R4: Each edge that has `fetchStep` high while running issues the current slot. The request appears on the outputs one cycle later with `reqSlot` = {bank, slot}. The slot then advances 0,1,…,7,0 and never leaves the bank.
- R5: The bank is taken from `bankSel` on the edge where the run bit goes from 0 to 1. Changes on `bankSel` while running are ignored.
- R6: A word with bit 8 set is decoded and its fields are shown on the outputs, but `reqValid` stays 0.
- R7: Access kind 11 is treated as no access: `reqValid` stays 0 and the fields are still shown.
- R8: Writing 0 to the run bit (`runWe` high, `runIn` low) resets the slot to 0. No request is issued on any edge where the sequencer is stopped.
- R9: An edge without `fetchStep` gives `reqValid` = 0 in the next cycle. The request fields and the slot position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddrWe | input | 1 | Load the program address |
| hostAddrIn | input | 4 | New program address |
| hostDataWe | input | 1 | Store a word and post-increment the address |
| hostDataIn | input | 9 | Micro-instruction word |
| runWe | input | 1 | Write the run bit |
| runIn | input | 1 | Run bit value |
| bankSel | input | 1 | Bank to use at run start (0 = A, 1 = B) |
| fetchStep | input | 1 | Fetch-cycle strobe |
| progAddr | output | 4 | Current program address |
| reqValid | output | 1 | Fetch request issued |
| reqPlane | output | 2 | Background plane |
| reqKind | output | 2 | Access kind (00 pixel data, 01 map-referenced pixel data, 10 map entry, 11 undefined) |
| reqOffset | output | 3 | Word offset |
| reqRotate | output | 1 | Rotation slot flag |
| reqSlot | output | 4 | Store address of the issued slot |

## Verification
A slot counter that is out of step shows at once on `reqSlot` and on the decoded fields of the next issued request. A bank register that changes in the middle of a run flips the top bit of `reqSlot` one cycle after the next step. A stale or badly decoded word shows as wrong fields, or as a wrong `reqValid`, in the cycle after the step that read it. A program address error shows on `progAddr` at the next edge, and again when the stored words are run back. The random mix of writes, run toggles and bank changes therefore finds a fault within one or two cycles of the first request it affects.

// File: rtl/bg_fetch_seq_pkg.sv
package bg_fetch_seq_pkg;

  localparam int WORD_W   = 9;
  localparam int PLANE_W  = 2;
  localparam int KIND_W   = 2;
  localparam int OFFSET_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_PIXEL    = 2'b00,
    KIND_MAP_PIX  = 2'b01,
    KIND_MAP      = 2'b10,
    KIND_UNDEF    = 2'b11
  } accessKind_t;

  typedef struct packed {
    logic                valid;
    logic [PLANE_W-1:0]  plane;
    accessKind_t         kind;
    logic [OFFSET_W-1:0] offset;
    logic                rotate;
  } fetchReq_t;

  localparam logic [WORD_W-1:0] NOP_WORD = 9'h100;

  function automatic fetchReq_t decodeWord(input logic [WORD_W-1:0] w);
    fetchReq_t r;
    r.rotate = w[5];
    r.offset = w[5] ? '0 : w[2:0];
    r.kind   = accessKind_t'(w[4:3]);
    r.plane  = w[7:6];
    r.valid  = !w[8] && (r.kind != KIND_UNDEF);
    return r;
  endfunction

endpackage

// File: rtl/bg_fetch_seq_ctrl.sv
module bg_fetch_seq_ctrl #(
  parameter int SLOTS = 8,
  parameter int BANKS = 2,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ADDR_W = $clog2(SLOTS * BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddrWe,
  input  logic [ADDR_W-1:0] hostAddrIn,
  input  logic              hostDataWe,
  input  logic              runWe,
  input  logic              runIn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              fetchStep,
  output logic [ADDR_W-1:0] progAddr,
  output logic              storeWr,
  output logic [ADDR_W-1:0] storeAddr,
  output logic              issue,
  output logic [ADDR_W-1:0] readAddr,
  output logic              runActive,
  output logic [BANK_W-1:0] bankActive
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              runQ;
  logic [BANK_W-1:0] bankQ;
  logic [SLOT_W-1:0] slotQ;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      runQ  <= 1'b0;
      bankQ <= '0;
      slotQ <= '0;
    end else begin
      if (hostAddrWe)      addrQ <= hostAddrIn;
      else if (hostDataWe) addrQ <= addrQ + 1'b1;

      if (runWe) begin
        runQ <= runIn;
        if (runIn && !runQ) bankQ <= bankSel;
      end

      if (runWe && !runIn)        slotQ <= '0;
      else if (runQ && fetchStep) slotQ <= (slotQ == LAST_SLOT) ? '0 : slotQ + 1'b1;
    end
  end

  always_comb begin
    storeWr    = hostDataWe;
    storeAddr  = addrQ;
    issue      = runQ && fetchStep;
    readAddr   = ADDR_W'({bankQ, slotQ});
    progAddr   = addrQ;
    runActive  = runQ;
    bankActive = bankQ;
  end

endmodule

// File: rtl/bg_fetch_seq_datapath.sv
module bg_fetch_seq_datapath
  import bg_fetch_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              storeWr,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [WORD_W-1:0] storeData,
  input  logic              issue,
  input  logic [ADDR_W-1:0] readAddr,
  output fetchReq_t         reqOut,
  output logic [ADDR_W-1:0] slotOut
);

  logic [WORD_W-1:0] store [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)                                   store[i] <= NOP_WORD;
      else if (storeWr && storeAddr == ADDR_W'(i)) store[i] <= storeData;
    end
  end

  fetchReq_t decoded;
  assign decoded = decodeWord(store[readAddr]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOut  <= '0;
      slotOut <= '0;
    end else if (issue) begin
      reqOut  <= decoded;
      slotOut <= readAddr;
    end else begin
      reqOut.valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
  import bg_fetch_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int BANKS = 2,
  localparam int ADDR_W = $clog2(SLOTS * BANKS),
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddrWe,
  input  logic [ADDR_W-1:0] hostAddrIn,
  input  logic              hostDataWe,
  input  logic [8:0]        hostDataIn,
  input  logic              runWe,
  input  logic              runIn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              fetchStep,
  output logic [ADDR_W-1:0] progAddr,
  output logic              reqValid,
  output logic [1:0]        reqPlane,
  output logic [1:0]        reqKind,
  output logic [2:0]        reqOffset,
  output logic              reqRotate,
  output logic [ADDR_W-1:0] reqSlot
);

  typedef struct packed {
    logic              storeWr;
    logic [ADDR_W-1:0] storeAddr;
    logic              issue;
    logic [ADDR_W-1:0] readAddr;
  } ctrlStrobes_t;

  ctrlStrobes_t      strobes;
  logic              runActive;
  logic [BANK_W-1:0] bankActive;
  fetchReq_t         req;

  bg_fetch_seq_ctrl #(.SLOTS(SLOTS), .BANKS(BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostAddrWe(hostAddrWe), .hostAddrIn(hostAddrIn),
    .hostDataWe(hostDataWe), .runWe(runWe), .runIn(runIn),
    .bankSel(bankSel), .fetchStep(fetchStep),
    .progAddr(progAddr),
    .storeWr(strobes.storeWr), .storeAddr(strobes.storeAddr),
    .issue(strobes.issue), .readAddr(strobes.readAddr),
    .runActive(runActive), .bankActive(bankActive)
  );

  bg_fetch_seq_datapath #(.DEPTH(SLOTS * BANKS)) u_dp (
    .clk(clk), .rstN(rstN),
    .storeWr(strobes.storeWr), .storeAddr(strobes.storeAddr),
    .storeData(hostDataIn),
    .issue(strobes.issue), .readAddr(strobes.readAddr),
    .reqOut(req), .slotOut(reqSlot)
  );

  assign reqValid  = req.valid;
  assign reqPlane  = req.plane;
  assign reqKind   = req.kind;
  assign reqOffset = req.offset;
  assign reqRotate = req.rotate;

endmodule

// File: rtl/bg_fetch_seq_checker.sv
module bg_fetch_seq_checker #(
  parameter int ADDR_W = 4,
  parameter int BANK_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAddrWe,
  input logic              hostDataWe,
  input logic              fetchStep,
  input logic [ADDR_W-1:0] progAddr,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [2:0]        reqOffset,
  input logic              reqRotate,
  input logic              runActive,
  input logic [BANK_W-1:0] bankActive
);

  AST_ADDR_POSTINC: assert property (@(posedge clk) disable iff (!rstN)
    hostDataWe && !hostAddrWe |=> progAddr == $past(progAddr) + 1'b1); // R2

  AST_ROT_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    reqRotate |-> reqOffset == 3'd0); // R3

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    runActive && $past(runActive) |-> $stable(bankActive)); // R5

  AST_UNDEF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqKind != 2'b11); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !runActive |=> !reqValid); // R8

  AST_STEP_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    !fetchStep |=> !reqValid); // R9

endmodule

bind bg_fetch_seq bg_fetch_seq_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostAddrWe(hostAddrWe), .hostDataWe(hostDataWe),
  .fetchStep(fetchStep), .progAddr(progAddr), .reqValid(reqValid),
  .reqKind(reqKind), .reqOffset(reqOffset), .reqRotate(reqRotate),
  .runActive(runActive), .bankActive(bankActive)
);

// File: tb/bg_fetch_seq_tb.sv
module bg_fetch_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostAddrWe = 0, hostDataWe = 0, runWe = 0, runIn = 0, bankSel = 0, fetchStep = 0;
  logic [3:0] hostAddrIn = '0;
  logic [8:0] hostDataIn = '0;
  logic [3:0] progAddr, reqSlot;
  logic reqValid, reqRotate;
  logic [1:0] reqPlane, reqKind;
  logic [2:0] reqOffset;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [8:0] mMem [16];
  logic [3:0] mAddr;
  logic       mRun, mBank;
  logic [2:0] mSlot;
  logic       eValid, eRot;
  logic [1:0] ePlane, eKind;
  logic [2:0] eOfs;
  logic [3:0] eSlot;

  bg_fetch_seq u_dut (
    .clk(clk), .rstN(rstN), .hostAddrWe(hostAddrWe), .hostAddrIn(hostAddrIn),
    .hostDataWe(hostDataWe), .hostDataIn(hostDataIn), .runWe(runWe), .runIn(runIn),
    .bankSel(bankSel), .fetchStep(fetchStep), .progAddr(progAddr),
    .reqValid(reqValid), .reqPlane(reqPlane), .reqKind(reqKind),
    .reqOffset(reqOffset), .reqRotate(reqRotate), .reqSlot(reqSlot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected model update for one edge, using the inputs now driven
  task automatic modelEdge();
    logic [8:0] w;
    if (mRun && fetchStep) begin
      w      = mMem[{mBank, mSlot}];
      eRot   = w[5];
      eOfs   = w[5] ? 3'd0 : w[2:0];
      eKind  = w[4:3];
      ePlane = w[7:6];
      eValid = (w[8] == 1'b0) && (w[4:3] != 2'b11);
      eSlot  = {mBank, mSlot};
    end else begin
      eValid = 1'b0;
    end
    if (hostDataWe) mMem[mAddr] = hostDataIn;
    if (hostAddrWe)      mAddr = hostAddrIn;
    else if (hostDataWe) mAddr = mAddr + 4'd1;
    if (runWe && !runIn)        mSlot = 3'd0;
    else if (mRun && fetchStep) mSlot = mSlot + 3'd1;
    if (runWe) begin
      if (runIn && !mRun) mBank = bankSel;
      mRun = runIn;
    end
  endtask

  task automatic compareAll();
    check("R2 progAddr", progAddr, mAddr);
    check("R6/R7/R8/R9 reqValid", reqValid, eValid);
    check("R4/R5 reqSlot", reqSlot, eSlot);
    check("R3 reqPlane", reqPlane, ePlane);
    check("R3 reqKind", reqKind, eKind);
    check("R3 reqOffset", reqOffset, eOfs);
    check("R3 reqRotate", reqRotate, eRot);
  endtask

  // inputs are driven at negedge; one edge; compare at next negedge
  task automatic cycle();
    modelEdge();
    @(negedge clk);
    compareAll();
    hostAddrWe = 0; hostDataWe = 0; runWe = 0; fetchStep = 0;
  endtask

  task automatic writeWord(input logic [8:0] w);
    hostDataWe = 1; hostDataIn = w; cycle();
  endtask

  task automatic setAddr(input logic [3:0] a);
    hostAddrWe = 1; hostAddrIn = a; cycle();
  endtask

  task automatic setRun(input logic r, input logic b);
    runWe = 1; runIn = r; bankSel = b; cycle();
  endtask

  task automatic step();
    fetchStep = 1; cycle();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) mMem[i] = 9'h100;
    mAddr = 0; mRun = 0; mBank = 0; mSlot = 0;
    eValid = 0; eRot = 0; ePlane = 0; eKind = 0; eOfs = 0; eSlot = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reqValid", reqValid, 0);
    check("R1 progAddr", progAddr, 0);
    check("R1 reqSlot", reqSlot, 0);
    // R1: fresh store is all no-access words
    setRun(1, 0);
    for (int i = 0; i < 8; i++) step();
    setRun(0, 0);

    // R2: sequential load of both banks, wrap check
    setAddr(4'd0);
    for (int i = 0; i < 16; i++) writeWord(9'(i * 37 + 5));
    check("R2 wrap to 0", progAddr, 0);
    // R3: rotation forces offset 0; R6 nop; R7 undefined kind
    setAddr(4'd2); writeWord(9'b0_10_1_10_111);  // rotate slot with offset bits
    setAddr(4'd3); writeWord(9'b1_01_0_01_011);  // NOP word
    setAddr(4'd4); writeWord(9'b0_11_0_11_110);  // kind 11
    setAddr(4'd5); writeWord(9'b0_11_0_10_101);  // valid map fetch
    // R4: run bank A, several laps
    setRun(1, 0);
    for (int i = 0; i < 20; i++) step();
    // R9: idle cycles hold
    cycle(); cycle();
    // R5: bank change while running ignored
    bankSel = 1; step(); step();
    // R8: stop resets slot, no requests while stopped
    setRun(0, 1);
    step(); step();
    // R5: new run picks bank B
    setRun(1, 1);
    for (int i = 0; i < 10; i++) step();
    // R2: simultaneous address load and data write
    hostAddrWe = 1; hostAddrIn = 4'd9; hostDataWe = 1; hostDataIn = 9'h0AA; cycle();
    setRun(0, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      hostAddrWe = ($urandom % 10) == 0;
      hostAddrIn = 4'($urandom);
      hostDataWe = ($urandom % 4) == 0;
      hostDataIn = 9'($urandom);
      runWe      = ($urandom % 20) == 0;
      runIn      = ($urandom % 3) != 0;
      bankSel    = 1'($urandom);
      fetchStep  = ($urandom % 5) < 3;
      cycle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule